// File: doc/BRIEF.md
# CPU Cycle Budget and Peripheral Tick Pacer

This block prices each executed instruction in CPU cycles and then spends that price in real time, so that the audio and video units stay in lockstep with the processor. When the core finishes resolving an instruction, it raises `start` and presents the following information:

- the base cycle count from its decode table;
- the page-cross flag from address generation;
- whether the instruction is a branch and, if so, whether the branch is taken;
- the branch target and the address of the following instruction.

The block works out the instruction's total cost and latches it. It then steps through that many CPU cycles.

All logic runs on one fast pixel clock, and every CPU cycle lasts `DOTS` fast clocks (three by default). During each fast clock of a CPU cycle the block raises `dot_tick` for the video unit. On the first fast clock of each CPU cycle it raises `aud_tick` for the audio unit. A 64-bit running counter adds one at the end of every CPU cycle spent. While a budget is being spent, `busy` is high and any new `start` is dropped.

Top module: `cbt_budget_tracker`

## Requirements
- R1: After reset, `busy`, `dot_tick` and `aud_tick` are 0, `instr_cycles` is 0 and `total_cycles` is 0.
- R2: For a start with `is_branch`=0, the latched cost on `instr_cycles` (visible one clock after the start) is `base_cycles` plus 1 when `page_cross`=1, or plus 0 otherwise.
- R3: A branch (`is_branch`=1) with `br_taken`=0 costs exactly 2 cycles. Both `base_cycles` and `page_cross` are ignored for branches.
- R4: A taken branch whose `br_target` bits [15:8] equal `next_pc` bits [15:8] costs 3 cycles.
- R5: A taken branch whose `br_target` bits [15:8] differ from `next_pc` bits [15:8] costs 4 cycles.
- R6: After an accepted start with cost N, `busy` is high for exactly 3·N consecutive fast clocks, and `dot_tick` is high on every one of them.
- R7: `aud_tick` pulses exactly N times per instruction, once on the first fast clock of each CPU cycle, and is never high on two consecutive clocks.
- R8: `total_cycles` grows by exactly N per instruction, in steps of one per completed CPU cycle, and holds otherwise.
- R9: A `start` while `busy` is high, including on the last busy clock, is ignored: `instr_cycles` and the remaining budget are unchanged, and no new run begins.
- R10: An accepted start whose cost is 0 latches 0 and raises neither `busy` nor any tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction cost is ready; accepted only when not busy |
| base_cycles | input | 4 | Base cycle count from decode |
| page_cross | input | 1 | Indexed address crossed a 256-byte page |
| is_branch | input | 1 | The instruction is a relative branch |
| br_taken | input | 1 | The branch condition holds |
| br_target | input | 16 | Branch destination address |
| next_pc | input | 16 | Address of the following instruction |
| busy | output | 1 | A budget is being spent |
| instr_cycles | output | 5 | Cost latched at the last accepted start |
| total_cycles | output | 64 | Running count of CPU cycles spent |
| dot_tick | output | 1 | Video dot enable, `DOTS` per CPU cycle |
| aud_tick | output | 1 | Audio enable, one per CPU cycle |

## Verification
Two events can fall on the same edge: a new `start` request, and the final fast clock of a budget, which is also when the counter takes its last step and `busy` falls. The bench drives `start` with different operands twice during a running budget. The first request comes early; the second lands exactly on the final busy clock. The bench then judges the outcome by three things: `instr_cycles` still shows the first cost, `busy` is low on the next clock, and the counter has moved by exactly the first cost.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  parameter int unsigned BASE_W = 4;
  localparam int unsigned COST_W = BASE_W + 1;

  localparam logic [COST_W-1:0] BR_NOT_TAKEN = COST_W'(2);
  localparam logic [COST_W-1:0] BR_TAKEN     = COST_W'(3);
  localparam logic [COST_W-1:0] BR_FAR       = COST_W'(4);

  // Pricing rule: branches are fixed-priced by outcome, everything else
  // pays its base plus a possible page-cross surcharge.
  function automatic logic [COST_W-1:0] instr_cost(
    input logic [BASE_W-1:0] base,
    input logic              pg_cross,
    input logic              is_br,
    input logic              taken,
    input logic              far_target
  );
    if (is_br) begin
      if (!taken)         return BR_NOT_TAKEN;
      else if (far_target) return BR_FAR;
      else                return BR_TAKEN;
    end
    return COST_W'(base) + COST_W'(pg_cross);
  endfunction
endpackage

// File: rtl/cbt_cost.sv
module cbt_cost
  import cbt_pkg::*;
#(
  parameter int unsigned PC_W      = 16,
  parameter int unsigned PAGE_BITS = 8
) (
  input  logic [BASE_W-1:0] base_cycles,
  input  logic              page_cross,
  input  logic              is_branch,
  input  logic              br_taken,
  input  logic [PC_W-1:0]   br_target,
  input  logic [PC_W-1:0]   next_pc,
  output logic              far_target,
  output logic [COST_W-1:0] cost
);
  localparam int unsigned PAGE_HI = PC_W - 1;

  assign far_target = br_target[PAGE_HI:PAGE_BITS] != next_pc[PAGE_HI:PAGE_BITS];
  assign cost = instr_cost(base_cycles, page_cross, is_branch, br_taken, far_target);

  // R3 / R5: a branch is always priced within 2..4
  always_comb begin
    if (is_branch === 1'b1 && br_taken !== 1'bx)
      p_branch_range_r3: assert (cost >= BR_NOT_TAKEN && cost <= BR_FAR);
  end
endmodule

// File: rtl/cbt_pacer.sv
module cbt_pacer
  import cbt_pkg::*;
#(
  parameter int unsigned DOTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [COST_W-1:0] load_cost,
  output logic              busy,
  output logic              dot_tick,
  output logic              aud_tick,
  output logic              cycle_step
);
  localparam int unsigned PH_W = (DOTS > 1) ? $clog2(DOTS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DOTS - 1);

  logic [COST_W-1:0] remaining;
  logic [PH_W-1:0]   phase;
  logic              phase_wrap;

  assign busy       = remaining != '0;
  assign phase_wrap = phase == PH_LAST;
  assign dot_tick   = busy;
  assign aud_tick   = busy && (phase == '0);
  assign cycle_step = busy && phase_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      phase     <= '0;
    end else if (load) begin
      remaining <= load_cost;
      phase     <= '0;
    end else if (busy) begin
      if (phase_wrap) begin
        phase     <= '0;
        remaining <= remaining - COST_W'(1);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  // R6: the dot phase never leaves its range
  p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_LAST);

  generate
    if (DOTS > 1) begin : g_multi_dot
      // R7: audio pulses are isolated
      p_aud_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        aud_tick && !load |=> !aud_tick);
    end
  endgenerate
endmodule

// File: rtl/cbt_counter.sv
module cbt_counter #(
  parameter int unsigned TOTAL_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  output logic [TOTAL_W-1:0] total
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) total <= '0;
    else if (step) total <= total + TOTAL_W'(1);
  end

  // R8: the counter advances by one per finished CPU cycle
  p_total_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> total == $past(total) + TOTAL_W'(1));
  p_total_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(total));
endmodule

// File: rtl/cbt_budget_tracker.sv
module cbt_budget_tracker
  import cbt_pkg::*;
#(
  parameter int unsigned PC_W      = 16,
  parameter int unsigned PAGE_BITS = 8,
  parameter int unsigned DOTS      = 3,
  parameter int unsigned TOTAL_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BASE_W-1:0]  base_cycles,
  input  logic               page_cross,
  input  logic               is_branch,
  input  logic               br_taken,
  input  logic [PC_W-1:0]    br_target,
  input  logic [PC_W-1:0]    next_pc,
  output logic               busy,
  output logic [COST_W-1:0]  instr_cycles,
  output logic [TOTAL_W-1:0] total_cycles,
  output logic               dot_tick,
  output logic               aud_tick
);
  logic [COST_W-1:0] cost_now;
  logic              far_target;
  logic              accept;
  logic              cycle_step;

  assign accept = start && !busy;

  cbt_cost #(.PC_W(PC_W), .PAGE_BITS(PAGE_BITS)) u_cost (
    .base_cycles(base_cycles), .page_cross(page_cross), .is_branch(is_branch),
    .br_taken(br_taken), .br_target(br_target), .next_pc(next_pc),
    .far_target(far_target), .cost(cost_now)
  );

  cbt_pacer #(.DOTS(DOTS)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_cost(cost_now),
    .busy(busy), .dot_tick(dot_tick), .aud_tick(aud_tick), .cycle_step(cycle_step)
  );

  cbt_counter #(.TOTAL_W(TOTAL_W)) u_count (
    .clk(clk), .rst_n(rst_n), .step(cycle_step), .total(total_cycles)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) instr_cycles <= '0;
    else if (accept) instr_cycles <= cost_now;
  end

  // R9: a start during a run leaves the latched cost alone
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(instr_cycles));
  // R9: a start during a run does not extend the run past its last clock
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cycle_step && instr_cycles == COST_W'(1) && start |=> !busy);
  // R10: a zero-cost instruction never makes the block busy
  p_zero_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cost_now == '0 |=> !busy && !dot_tick);
  // R2: the latched cost follows the inputs of the accepted start
  p_latch_cost_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> instr_cycles == $past(cost_now));
endmodule

// File: tb/cbt_budget_tracker_test.sv
`timescale 1ns/1ps
module cbt_budget_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  base_cycles = '0;
  logic        page_cross = 1'b0;
  logic        is_branch = 1'b0;
  logic        br_taken = 1'b0;
  logic [15:0] br_target = '0;
  logic [15:0] next_pc = '0;
  logic        busy;
  logic [4:0]  instr_cycles;
  logic [63:0] total_cycles;
  logic        dot_tick;
  logic        aud_tick;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cbt_budget_tracker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_cycles(base_cycles),
    .page_cross(page_cross), .is_branch(is_branch), .br_taken(br_taken),
    .br_target(br_target), .next_pc(next_pc), .busy(busy),
    .instr_cycles(instr_cycles), .total_cycles(total_cycles),
    .dot_tick(dot_tick), .aud_tick(aud_tick)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Independent pricing model written from the requirements
  function automatic int model_cost(input int b, input bit pc, input bit br, input bit tk,
                                    input logic [15:0] tgt, input logic [15:0] npc);
    if (br) return !tk ? 2 : ((tgt >> 8) == (npc >> 8) ? 3 : 4);
    return b + (pc ? 1 : 0);
  endfunction

  task automatic run_case(input int b, input bit pc, input bit br, input bit tk,
                          input logic [15:0] tgt, input logic [15:0] npc, input string req);
    longint t0 = longint'(total_cycles);
    int exp = model_cost(b, pc, br, tk, tgt, npc);
    int nbusy = 0, ndot = 0, naud = 0;
    base_cycles = 4'(b); page_cross = pc; is_branch = br; br_taken = tk;
    br_target = tgt; next_pc = npc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(instr_cycles == 5'(exp), req, longint'(instr_cycles), exp);
    while (busy) begin
      nbusy++; ndot += int'(dot_tick); naud += int'(aud_tick);
      @(negedge clk);
    end
    check(nbusy == 3 * exp, "R6 busy length", nbusy, 3 * exp);
    check(ndot == 3 * exp, "R6 dot count", ndot, 3 * exp);
    check(naud == exp, "R7 audio count", naud, exp);
    check(longint'(total_cycles) - t0 == exp, "R8 counter delta",
          longint'(total_cycles) - t0, exp);
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(dot_tick == 1'b0 && aud_tick == 1'b0, "R1 ticks", dot_tick | aud_tick, 0);
    check(instr_cycles == 0, "R1 instr_cycles", instr_cycles, 0);
    check(total_cycles == 0, "R1 total", longint'(total_cycles), 0);
  endtask

  task automatic t_plain;
    run_case(2, 0, 0, 0, 16'h0000, 16'h0000, "R2 immediate");
    run_case(3, 0, 0, 0, 16'h0000, 16'h0000, "R2 zero page");
    run_case(4, 1, 0, 0, 16'h0000, 16'h0000, "R2 page cross");
    run_case(5, 1, 0, 0, 16'h0000, 16'h0000, "R2 indirect page cross");
  endtask

  task automatic t_branch;
    run_case(9, 1, 1, 0, 16'h4480, 16'h1210, "R3 not taken");
    run_case(7, 0, 1, 1, 16'h12F0, 16'h1205, "R4 taken near");
    run_case(1, 1, 1, 1, 16'h1302, 16'h12FE, "R5 taken far");
    run_case(0, 0, 1, 1, 16'h11FF, 16'h1200, "R5 taken far backward");
  endtask

  task automatic t_zero;
    run_case(0, 0, 0, 0, 16'h0000, 16'h0000, "R10 zero cost");
    check(busy == 1'b0 && aud_tick == 1'b0, "R10 idle", busy, 0);
  endtask

  task automatic t_busy_start;
    longint t0 = longint'(total_cycles);
    int nbusy = 0;
    base_cycles = 4'd3; page_cross = 1'b0; is_branch = 1'b0; br_taken = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) begin
      nbusy++;
      if (nbusy == 2)      begin start = 1'b1; base_cycles = 4'd9; end
      else if (nbusy == 9) begin start = 1'b1; base_cycles = 4'd5; end
      else start = 1'b0;
      @(negedge clk);
      check(instr_cycles == 5'd3, "R9 latched cost held", instr_cycles, 3);
    end
    start = 1'b0;
    check(nbusy == 9, "R9 run length unchanged", nbusy, 9);
    check(busy == 1'b0, "R9 no new run", busy, 0);
    check(longint'(total_cycles) - t0 == 3, "R9 counter delta",
          longint'(total_cycles) - t0, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_branch();
    t_zero();
    t_busy_start();
    run_case(6, 1, 0, 0, 16'h0000, 16'h0000, "R2 after ignored start");
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule